// File: doc/BRIEF.md
# Transmit Mailbox Arbitration Scanner

This block picks the next frame a CAN controller sends. The controller keeps a bank of message buffers. Each buffer holds a state code, a 29-bit identifier, the frame-format (IDE) and remote-request (RTR) bits, and a small local priority value. When the frame engine pulses `scan_trig`, the block walks the bank one buffer per clock. It drives the buffer number on `rd_idx` and reads that buffer's fields back in the same cycle. When the walk is done it reports the winning buffer on `win_idx`.

There are two selection rules, picked by a mode input. The first takes the lowest-numbered buffer that is waiting to send. The second takes the buffer with the smallest arbitration key. The key is the identifier laid out in the order the bits go on the wire: the 11-bit base identifier, then the bits that follow it, then the 18-bit extension. An optional local priority field can be placed above this. The frame engine pulses the trigger while the CRC field of the current frame is on the bus, and again during an error delimiter.

Top module: `tx_mailbox_arbiter`

## Requirements
- R1: After reset, `res_done` and `win_hit` are 0 and `win_idx` is 0.
- R2: Only buffers with code 4'b1100 (send data) or 4'b1110 (send remote-answer) take part. Every other code is skipped, including 4'b1000 (inactive), 4'b1001 (abort) and 4'b0000.
- R3: With `lowbuf_mode` = 1, the winner is the lowest-numbered buffer that takes part.
- R4: With `lowbuf_mode` = 0, the winner is the buffer with the numerically smallest key. A smaller key means higher priority.
- R5: Each key is 32 bits. An extended frame (IDE = 1) has the key {id[28:18], 1, 1, id[17:0], RTR}. A standard frame has the key {id[28:18], RTR, 0, 19'b0}.
- R6: With `lprio_en` = 1, the buffer's priority field is placed above the 32-bit key. With `lprio_en` = 0, that field reads as zero.
- R7: When two keys are equal, the lower buffer number wins.
- R8: The scan visits one buffer per clock. On the k-th clock after the trigger edge, `rd_idx` is k-1. `res_done` rises on the clock after the last buffer is read.
- R9: `res_done`, `win_hit` and `win_idx` are cleared on the trigger edge and stay at 0 during the scan. A trigger that arrives during a scan restarts it at buffer 0.
- R10: `lowbuf_mode` and `lprio_en` are sampled on the trigger edge. A change to them during the scan has no effect on that scan.
- R11: If no buffer takes part, the scan ends with `res_done` = 1 and `win_hit` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_trig | input | 1 | One-cycle scan start |
| lowbuf_mode | input | 1 | 1: lowest buffer number wins; 0: lowest key wins |
| lprio_en | input | 1 | Place the local priority field above the key |
| rd_idx | output | $clog2(NUM_BUF) | Buffer being read |
| mb_code | input | 4 | State code of the buffer being read |
| mb_id | input | 29 | Identifier of the buffer being read |
| mb_ide | input | 1 | Extended-format bit of the buffer being read |
| mb_rtr | input | 1 | Remote-request bit of the buffer being read |
| mb_prio | input | PRIO_W | Local priority of the buffer being read |
| res_done | output | 1 | A scan has completed and the result is valid |
| win_hit | output | 1 | The completed scan found a buffer to send |
| win_idx | output | $clog2(NUM_BUF) | Winning buffer number |

## Verification
The bench builds the block with NUM_BUF = 6 and PRIO_W = 2, so a full scan takes only a few cycles. With six buffers there is room for a mix of skipped codes, key ties and standard-versus-extended frames, and the last buffer is index 5, not a power-of-two boundary. A two-bit priority field lets a low priority value outrank a buffer whose identifier is much smaller. Restarts are placed both in the middle of a scan and on its last buffer.

// File: rtl/tx_mailbox_arbiter.sv
module tx_mailbox_arbiter #(
  parameter int NUM_BUF = 16,
  parameter int PRIO_W  = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scan_trig,
  input  logic                       lowbuf_mode,
  input  logic                       lprio_en,
  output logic [$clog2(NUM_BUF)-1:0] rd_idx,
  input  logic [3:0]                 mb_code,
  input  logic [28:0]                mb_id,
  input  logic                       mb_ide,
  input  logic                       mb_rtr,
  input  logic [PRIO_W-1:0]          mb_prio,
  output logic                       res_done,
  output logic                       win_hit,
  output logic [$clog2(NUM_BUF)-1:0] win_idx
);
  localparam int IDX_W = $clog2(NUM_BUF);
  localparam int FK_W  = 32;
  localparam int KEY_W = PRIO_W + FK_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_BUF - 1);
  localparam logic [3:0] CODE_TX_DATA = 4'b1100;
  localparam logic [3:0] CODE_TX_RANS = 4'b1110;

  logic             busy, found, lb_q, pe_q;
  logic [IDX_W-1:0] idx, best_idx;
  logic [KEY_W-1:0] best_key;

  wire pend = (mb_code == CODE_TX_DATA) || (mb_code == CODE_TX_RANS);

  wire [FK_W-1:0] frame_key = mb_ide ?
    {mb_id[28:18], 1'b1, 1'b1, mb_id[17:0], mb_rtr} :
    {mb_id[28:18], mb_rtr, 1'b0, 19'b0};

  wire [KEY_W-1:0] cur_key = {pe_q ? mb_prio : {PRIO_W{1'b0}}, frame_key};

  wire better = pend && (!found || (!lb_q && (cur_key < best_key)));

  assign rd_idx = idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      found    <= 1'b0;
      lb_q     <= 1'b0;
      pe_q     <= 1'b0;
      idx      <= '0;
      best_idx <= '0;
      best_key <= '0;
      res_done <= 1'b0;
      win_hit  <= 1'b0;
      win_idx  <= '0;
    end else if (scan_trig) begin
      busy     <= 1'b1;
      found    <= 1'b0;
      lb_q     <= lowbuf_mode;
      pe_q     <= lprio_en;
      idx      <= '0;
      res_done <= 1'b0;
      win_hit  <= 1'b0;
      win_idx  <= '0;
    end else if (busy) begin
      if (better) begin
        found    <= 1'b1;
        best_key <= cur_key;
        best_idx <= idx;
      end
      if (idx == LAST) begin
        busy     <= 1'b0;
        res_done <= 1'b1;
        win_hit  <= found | better;
        win_idx  <= better ? idx : best_idx;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

module tx_mailbox_arbiter_chk #(
  parameter int IDX_W    = 4,
  parameter int LAST_IDX = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scan_trig,
  input logic             busy,
  input logic             res_done,
  input logic             win_hit,
  input logic [IDX_W-1:0] rd_idx,
  input logic [IDX_W-1:0] win_idx
);
  // R9
  done_low_in_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !res_done);

  // R9
  trig_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_trig |=> (!res_done && !win_hit && rd_idx == '0 && busy));

  // R11
  hit_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> res_done);

  // R8
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !scan_trig && rd_idx != IDX_W'(LAST_IDX)) |=> (rd_idx == $past(rd_idx) + IDX_W'(1)));

  // R8
  end_of_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !scan_trig && rd_idx == IDX_W'(LAST_IDX)) |=> (res_done && !busy));

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && !scan_trig) |=> (res_done && $stable(win_idx) && $stable(win_hit)));
endmodule

bind tx_mailbox_arbiter tx_mailbox_arbiter_chk #(
  .IDX_W($clog2(NUM_BUF)),
  .LAST_IDX(NUM_BUF - 1)
) u_chk (
  .clk(clk), .rst_n(rst_n), .scan_trig(scan_trig), .busy(busy),
  .res_done(res_done), .win_hit(win_hit), .rd_idx(rd_idx), .win_idx(win_idx)
);

// File: tb/tx_mailbox_arbiter_tb.sv
module tx_mailbox_arbiter_tb;
  localparam int N     = 6;
  localparam int PW    = 2;
  localparam int IW    = $clog2(N);
  localparam int KW    = PW + 32;

  logic clk = 0, rst_n = 0, scan_trig = 0, lowbuf_mode = 0, lprio_en = 0;
  logic [IW-1:0] rd_idx, win_idx;
  logic res_done, win_hit;
  logic [3:0]    c_code [N];
  logic [28:0]   c_id   [N];
  logic          c_ide  [N];
  logic          c_rtr  [N];
  logic [PW-1:0] c_prio [N];

  logic [3:0]    mb_code;
  logic [28:0]   mb_id;
  logic          mb_ide, mb_rtr;
  logic [PW-1:0] mb_prio;
  assign mb_code = c_code[rd_idx];
  assign mb_id   = c_id[rd_idx];
  assign mb_ide  = c_ide[rd_idx];
  assign mb_rtr  = c_rtr[rd_idx];
  assign mb_prio = c_prio[rd_idx];

  tx_mailbox_arbiter #(.NUM_BUF(N), .PRIO_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .scan_trig(scan_trig), .lowbuf_mode(lowbuf_mode),
    .lprio_en(lprio_en), .rd_idx(rd_idx), .mb_code(mb_code), .mb_id(mb_id),
    .mb_ide(mb_ide), .mb_rtr(mb_rtr), .mb_prio(mb_prio), .res_done(res_done),
    .win_hit(win_hit), .win_idx(win_idx));

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  string cur_req = "R1";

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [KW-1:0] ref_key(int i, bit pe);
    logic [31:0] fk;
    if (c_ide[i]) fk = {c_id[i][28:18], 2'b11, c_id[i][17:0], c_rtr[i]};
    else          fk = {c_id[i][28:18], c_rtr[i], 1'b0, 19'd0};
    return {pe ? c_prio[i] : {PW{1'b0}}, fk};
  endfunction

  // Behavioural reference
  bit m_busy = 0, m_done = 0, m_hit = 0, m_lb = 0, m_pe = 0;
  int m_cnt = 0, m_idx = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_hit = 0; m_idx = 0; m_cnt = 0;
    end else if (scan_trig) begin
      m_busy = 1; m_done = 0; m_hit = 0; m_idx = 0; m_cnt = 0;
      m_lb = lowbuf_mode; m_pe = lprio_en;
    end else if (m_busy) begin
      if (m_cnt == N - 1) begin
        logic [KW-1:0] bk;
        m_busy = 0; m_done = 1; m_hit = 0; m_idx = 0; bk = '0;
        for (int i = 0; i < N; i++) begin
          if (c_code[i] == 4'b1100 || c_code[i] == 4'b1110) begin
            if (!m_hit || (!m_lb && ref_key(i, m_pe) < bk)) begin
              m_hit = 1; m_idx = i; bk = ref_key(i, m_pe);
            end
          end
        end
      end else m_cnt++;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk(res_done == m_done, cur_req, "res_done", res_done, m_done);
      chk(win_hit == m_hit, cur_req, "win_hit", win_hit, m_hit);
      chk(int'(win_idx) == m_idx, cur_req, "win_idx", win_idx, m_idx);
      if (m_busy) chk(int'(rd_idx) == m_cnt, "R8", "rd_idx", rd_idx, m_cnt);
    end
    if (cycles > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic setb(int i, logic [3:0] code, int base, int ext, bit ide, bit rtr, int prio);
    c_code[i] = code; c_id[i] = {11'(base), 18'(ext)};
    c_ide[i] = ide; c_rtr[i] = rtr; c_prio[i] = PW'(prio);
  endtask

  task automatic scan(bit lb, bit pe, string req, bit exp_hit, int exp_idx);
    cur_req = req; lowbuf_mode = lb; lprio_en = pe; scan_trig = 1;
    @(negedge clk); scan_trig = 0;
    repeat (N + 1) @(negedge clk);
    chk(res_done == 1'b1, req, "scan done", res_done, 1);
    chk(win_hit == exp_hit, req, "hit", win_hit, exp_hit);
    if (exp_hit) chk(int'(win_idx) == exp_idx, req, "winner", win_idx, exp_idx);
  endtask

  initial begin
    for (int i = 0; i < N; i++) setb(i, 4'b0000, i + 1, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(res_done == 0 && win_hit == 0 && win_idx == 0, "R1", "reset outputs",
        {res_done, win_hit, win_idx}, 0);

    // R11 nothing pending: inactive, abort and empty codes
    setb(1, 4'b1000, 3, 0, 0, 0, 0);
    setb(2, 4'b1001, 2, 0, 0, 0, 0);
    scan(0, 0, "R11", 0, 0);
    scan(1, 0, "R11", 0, 0);

    // R2 only send codes take part
    setb(0, 4'b1000, 1, 0, 0, 0, 0);
    setb(1, 4'b1001, 2, 0, 0, 0, 0);
    setb(2, 4'b0000, 3, 0, 0, 0, 0);
    setb(3, 4'b1100, 50, 0, 0, 0, 0);
    setb(4, 4'b1110, 40, 0, 0, 0, 0);
    setb(5, 4'b0100, 5, 0, 0, 0, 0);
    scan(0, 0, "R2", 1, 4);
    scan(1, 0, "R2", 1, 3);

    // R3 / R4 lowest buffer versus lowest key
    setb(2, 4'b1100, 99, 0, 0, 0, 0);
    scan(1, 0, "R3", 1, 2);
    scan(0, 0, "R4", 1, 4);
    setb(5, 4'b1110, 40, 5, 1, 0, 0);
    setb(0, 4'b1100, 45, 0, 0, 0, 0);
    scan(0, 0, "R4", 1, 4);
    scan(1, 0, "R3", 1, 0);
    setb(0, 4'b0000, 1, 0, 0, 0, 0);
    setb(5, 4'b0000, 5, 0, 0, 0, 0);

    // R5 key layout: standard beats extended with same base; RTR ordering
    setb(2, 4'b0000, 99, 0, 0, 0, 0);
    setb(3, 4'b1100, 40, 0, 0, 0, 0);
    setb(4, 4'b1100, 40, 0, 1, 0, 0);
    scan(0, 0, "R5", 1, 3);
    setb(3, 4'b1100, 40, 0, 0, 1, 0);
    scan(0, 0, "R5", 1, 3);
    setb(4, 4'b1100, 40, 0, 0, 0, 0);
    scan(0, 0, "R5", 1, 4);
    setb(3, 4'b1100, 40, 7, 1, 0, 0);
    setb(4, 4'b1100, 40, 6, 1, 1, 0);
    scan(0, 0, "R5", 1, 4);

    // R6 local priority above the key
    setb(3, 4'b1100, 10, 0, 0, 0, 3);
    setb(4, 4'b1100, 20, 0, 0, 0, 0);
    scan(0, 1, "R6", 1, 4);
    scan(0, 0, "R6", 1, 3);

    // R7 equal keys
    setb(3, 4'b0000, 10, 0, 0, 0, 0);
    setb(1, 4'b1100, 7, 0, 0, 0, 1);
    setb(4, 4'b1110, 7, 0, 0, 0, 1);
    scan(0, 1, "R7", 1, 1);
    scan(0, 0, "R7", 1, 1);

    // R9 restart mid-scan and on the last buffer
    cur_req = "R9"; lowbuf_mode = 0; scan_trig = 1;
    @(negedge clk); scan_trig = 0;
    repeat (2) @(negedge clk);
    chk(res_done == 0, "R9", "done during scan", res_done, 0);
    scan_trig = 1; @(negedge clk); scan_trig = 0;
    repeat (N - 1) @(negedge clk);
    chk(int'(rd_idx) == N - 1, "R9", "last buffer read", rd_idx, N - 1);
    scan_trig = 1; @(negedge clk); scan_trig = 0;
    chk(res_done == 0, "R9", "no completion after late restart", res_done, 0);
    repeat (N + 1) @(negedge clk);
    chk(res_done == 1 && int'(win_idx) == 1, "R9", "winner after restart", win_idx, 1);

    // R10 mode inputs changed mid-scan are ignored
    setb(1, 4'b1100, 30, 0, 0, 0, 0);
    cur_req = "R10"; lowbuf_mode = 1; lprio_en = 0; scan_trig = 1;
    @(negedge clk); scan_trig = 0; lowbuf_mode = 0; lprio_en = 1;
    repeat (N) @(negedge clk);
    chk(res_done == 1 && int'(win_idx) == 1, "R10", "latched lowbuf", win_idx, 1);

    // R8 done timing
    cur_req = "R8"; scan_trig = 1;
    @(negedge clk); scan_trig = 0;
    repeat (N - 1) @(negedge clk);
    chk(res_done == 0, "R8", "done one cycle early", res_done, 0);
    @(negedge clk);
    chk(res_done == 1, "R8", "done on time", res_done, 1);

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule